// File: doc/BRIEF.md
# Dual-Mode Programmable Channel Divider

This block is the programmable divide-by-N counter of a phase-locked channel synthesizer. It runs on the divider input clock and gives one pulse, one clock wide, every N clock cycles. The phase comparator that follows uses this pulse. The ratio N comes from an 8-bit program port. A mode input selects how that port is read.

With the mode input low, the port is a plain binary ratio. With the mode input high, the low six bits are a two-digit decimal channel code. The block converts this code to binary and adds a fixed offset of 90. A code that cannot be divided by is flagged on an inhibit output, and the counter stops while the flag is up. An example is a ratio below three, which can come from a switch that lost contact and let every line fall to zero. Such a code never produces a spurious output frequency, and the transmitter can be muted from the flag. A new ratio takes effect only when the current period ends.

Top module: `chan_divider`

## Requirements
- R1: With `bcd_mode` low, the ratio is the unsigned value of `prog`. Every value from 3 to 255 gives a `div_pulse` period of exactly that many clock cycles.
- R2: With `bcd_mode` high, the units digit is `prog[3:0]` and the tens digit is `prog[5:4]`. The ratio is 90 + 10·tens + units, which gives 90 to 129. `prog[7:6]` has no effect.
- R3: `div_pulse` is high for exactly one clock at the end of each period and is never high on two consecutive clocks.
- R4: `inhibit` is high in the cycle after any rising edge at which the program is illegal, and low after an edge at which it is legal. In binary mode a value below 3 is illegal, including all-zero (open switches). In BCD mode a units digit above 9 is illegal.
- R5: While `inhibit` is high, `div_pulse` stays low and the count is held cleared. The first rising edge that sees a legal program raises `div_pulse` and starts a full period of the new ratio.
- R6: A change of `prog` or `bcd_mode` during a period does not shorten or lengthen that period. The new ratio governs the period that starts at the next terminal count.
- R7: While the synchronous reset `rst` is high at a rising edge, `div_pulse` and `inhibit` go low. The first rising edge after its release that sees a legal program raises `div_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog | input | 8 | Program word: binary ratio, or a BCD channel code in bits 5..0 |
| bcd_mode | input | 1 | 0 selects binary reading, 1 selects BCD reading with offset |
| div_pulse | output | 1 | One-clock pulse at each terminal count |
| inhibit | output | 1 | High while the program word is illegal |

## Verification
The bench walks every binary ratio from 3 to 255 and all forty legal BCD codes, and measures the gap between pulses. An off-by-one reload would show up as every period being one cycle long or short. A wrong weighting of the tens digit would move only codes with a non-zero tens digit. Ratios 0, 1, 2 and all six out-of-range units digits at each tens digit are applied. A design that decoded them loosely would keep pulsing with no inhibit. Changing the ratio mid-period checks that the running period finishes at the old length, and garbage in bits 7..6 during BCD mode checks that they are ignored. A cycle-by-cycle model also catches a late first pulse after reset or after inhibit clears.

// File: rtl/chan_div_pkg.sv
package chan_div_pkg;

    // Width of the program word and of the divide ratio
    localparam int unsigned RATIO_W = 8;

    // Result of decoding the program inputs
    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               bad;
    } ratio_sel_t;

endpackage

// File: rtl/ratio_decode.sv
module ratio_decode
    import chan_div_pkg::*;
#(
    parameter int unsigned MIN_RATIO  = 3,
    parameter int unsigned BCD_OFFSET = 90,
    parameter int unsigned UNIT_W     = 4,
    parameter int unsigned TENS_W     = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] prog,
    input  logic               bcd_mode,
    output ratio_sel_t         sel
);

    localparam int unsigned BCD_MAX = BCD_OFFSET + 10 * ((2 ** TENS_W) - 1) + 9;

    logic [UNIT_W-1:0]  units;
    logic [TENS_W-1:0]  tens;
    logic [RATIO_W-1:0] bcd_ratio;

    always_comb begin
        units     = prog[UNIT_W-1:0];
        tens      = prog[UNIT_W+TENS_W-1:UNIT_W];
        bcd_ratio = RATIO_W'(BCD_OFFSET)
                  + (RATIO_W'(tens) << 3) + (RATIO_W'(tens) << 1)
                  + RATIO_W'(units);
        if (bcd_mode) begin
            sel.ratio = bcd_ratio;
            sel.bad   = (units > UNIT_W'(9));
        end else begin
            sel.ratio = prog;
            sel.bad   = (prog < RATIO_W'(MIN_RATIO));
        end
    end

    // R2: a legal decimal code always lands inside the offset window
    p_bcd_window_r2: assert property (@(posedge clk) disable iff (rst)
        (bcd_mode && !sel.bad) |->
            (sel.ratio >= RATIO_W'(BCD_OFFSET) && sel.ratio <= RATIO_W'(BCD_MAX)));

    // R4: nothing below the minimum ratio ever reaches the counter as legal
    p_min_ratio_r4: assert property (@(posedge clk) disable iff (rst)
        !sel.bad |-> sel.ratio >= RATIO_W'(MIN_RATIO));

endmodule

// File: rtl/div_counter.sv
module div_counter
    import chan_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ratio_sel_t sel,
    output logic       pulse_o,
    output logic       inhibit_o
);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               pulse;
        logic               inh;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.inh   = sel.bad;
        st_d.pulse = 1'b0;
        if (sel.bad) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == '0) begin
            st_d.cnt   = sel.ratio - RATIO_W'(1);
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - RATIO_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o   = st_q.pulse;
    assign inhibit_o = st_q.inh;

    // R3: pulses are isolated
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |=> !st_q.pulse);

    // R5: no output while inhibited
    p_quiet_inhibit_r5: assert property (@(posedge clk) disable iff (rst)
        st_q.inh |-> !st_q.pulse);

    // R5: an illegal program leaves the count cleared
    p_hold_cleared_r5: assert property (@(posedge clk) disable iff (rst)
        sel.bad |=> st_q.cnt == '0);

    // R6: a pulse only follows a count that had run out
    p_pulse_at_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |-> $past(st_q.cnt) == '0);

endmodule

// File: rtl/chan_divider.sv
module chan_divider
    import chan_div_pkg::*;
#(
    parameter int unsigned MIN_RATIO  = 3,
    parameter int unsigned BCD_OFFSET = 90
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] prog,
    input  logic               bcd_mode,
    output logic               div_pulse,
    output logic               inhibit
);

    ratio_sel_t sel;

    ratio_decode #(
        .MIN_RATIO  (MIN_RATIO),
        .BCD_OFFSET (BCD_OFFSET),
        .UNIT_W     (4),
        .TENS_W     (2)
    ) decode_i (
        .clk      (clk),
        .rst      (rst),
        .prog     (prog),
        .bcd_mode (bcd_mode),
        .sel      (sel)
    );

    div_counter count_i (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .pulse_o   (div_pulse),
        .inhibit_o (inhibit)
    );

    // R4: inhibit and a pulse never coincide at the ports
    p_port_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(inhibit && div_pulse));

endmodule

// File: tb/chan_divider_tb_top.sv
module chan_divider_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] prog = 8'd0;
    logic       bcd_mode = 1'b0;
    logic       div_pulse;
    logic       inhibit;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    chan_divider dut_i (
        .clk       (clk),
        .rst       (rst),
        .prog      (prog),
        .bcd_mode  (bcd_mode),
        .div_pulse (div_pulse),
        .inhibit   (inhibit)
    );

    // Reference decode written from the requirements
    task automatic ref_decode(input bit bcd, input int p, output int r, output bit bad);
        int u, t;
        if (bcd) begin
            u   = p % 16;
            t   = (p / 16) % 4;
            bad = (u > 9);
            r   = 90 + 10 * t + u;
        end else begin
            r   = p;
            bad = (p < 3);
        end
    endtask

    // Behavioural model: cycles left until the next pulse
    int m_left = 0;
    bit m_pulse = 1'b0;
    bit m_inh = 1'b0;
    bit m_live = 1'b0;

    always @(posedge clk) begin
        int r;
        bit bad;
        m_live = 1'b1;
        if (rst) begin
            m_left  = 0;
            m_pulse = 1'b0;
            m_inh   = 1'b0;
        end else begin
            ref_decode(bcd_mode, int'(prog), r, bad);
            m_inh = bad;
            if (bad) begin
                m_left  = 0;
                m_pulse = 1'b0;
            end else if (m_left == 0) begin
                m_pulse = 1'b1;
                m_left  = r - 1;
            end else begin
                m_pulse = 1'b0;
                m_left  = m_left - 1;
            end
        end
    end

    // Per-clock comparison against the model (R1 R2 R3 R4 R5 R6 R7)
    always @(negedge clk) begin
        if (m_live) begin
            checks++;
            if (div_pulse !== m_pulse) begin
                errors++;
                $display("FAIL R3 model pulse at %0t: got %b expected %b", $time, div_pulse, m_pulse);
            end
            checks++;
            if (inhibit !== m_inh) begin
                errors++;
                $display("FAIL R4 model inhibit at %0t: got %b expected %b", $time, inhibit, m_inh);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns the length of the first full period after it
    task automatic measure(output int gap);
        int n = 0;
        @(negedge clk);
        while (div_pulse !== 1'b1 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (div_pulse !== 1'b1 && gap < 1000);
    endtask

    task automatic set_prog(input bit bcd, input int p);
        bcd_mode = bcd;
        prog     = 8'(p);
    endtask

    initial begin
        int gap;
        // R7: reset state
        set_prog(1'b0, 5);
        repeat (3) @(negedge clk);
        chk(div_pulse === 1'b0, "R7 pulse in reset", int'(div_pulse), 0);
        chk(inhibit === 1'b0, "R7 inhibit in reset", int'(inhibit), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(div_pulse === 1'b1, "R7 first pulse after release", int'(div_pulse), 1);
        @(negedge clk);
        chk(div_pulse === 1'b0, "R3 pulse width", int'(div_pulse), 0);

        // R1: every legal binary ratio
        for (int v = 3; v <= 255; v++) begin
            set_prog(1'b0, v);
            measure(gap);
            chk(gap == v, $sformatf("R1 binary period N=%0d", v), gap, v);
        end

        // R2: every legal decimal code, upper bits set to check they are ignored
        for (int t = 0; t < 4; t++) begin
            for (int u = 0; u < 10; u++) begin
                set_prog(1'b1, ((t * 3) % 4) * 64 + t * 16 + u);
                measure(gap);
                chk(gap == 90 + 10 * t + u, $sformatf("R2 bcd period t=%0d u=%0d", t, u),
                    gap, 90 + 10 * t + u);
            end
        end

        // R4 R5: illegal binary values, including open switches
        for (int v = 0; v < 3; v++) begin
            set_prog(1'b0, v);
            repeat (2) @(negedge clk);
            chk(inhibit === 1'b1, $sformatf("R4 inhibit binary %0d", v), int'(inhibit), 1);
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                chk(div_pulse === 1'b0, "R5 no pulse while inhibited", int'(div_pulse), 0);
            end
        end
        // R5: legal code restarts at once
        set_prog(1'b0, 7);
        @(negedge clk);
        chk(div_pulse === 1'b1, "R5 pulse on first legal edge", int'(div_pulse), 1);
        chk(inhibit === 1'b0, "R4 inhibit cleared", int'(inhibit), 0);
        measure(gap);
        chk(gap == 7, "R5 full period after inhibit", gap, 7);

        // R4: illegal units digits at every tens digit
        for (int t = 0; t < 4; t++) begin
            for (int u = 10; u < 16; u++) begin
                set_prog(1'b1, t * 16 + u);
                repeat (2) @(negedge clk);
                chk(inhibit === 1'b1, $sformatf("R4 inhibit bcd t=%0d u=%0d", t, u), int'(inhibit), 1);
                chk(div_pulse === 1'b0, "R5 pulse held low", int'(div_pulse), 0);
            end
        end

        // R6: change mid-period does not cut the running period
        set_prog(1'b0, 40);
        measure(gap);
        repeat (10) @(negedge clk);
        set_prog(1'b0, 6);
        gap = 10;
        do begin
            @(negedge clk);
            gap++;
        end while (div_pulse !== 1'b1 && gap < 1000);
        chk(gap == 40, "R6 running period kept", gap, 40);
        measure(gap);
        chk(gap == 6, "R6 new ratio next period", gap, 6);

        // R7: reset in mid-count
        set_prog(1'b0, 100);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(div_pulse === 1'b0 && inhibit === 1'b0, "R7 mid-run reset", int'(div_pulse), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(div_pulse === 1'b1, "R7 restart after reset", int'(div_pulse), 1);
        repeat (3) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog R1: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule